// File: doc/BRIEF.md
# Multi-Rate Half-Band Interpolation Upsampler

This block raises the sample rate of a 24-bit signed PCM stream so that every input rate class reaches one common output rate. It is a cascade of three 2x interpolation stages. Each stage is a linear-phase half-band FIR whose symmetric coefficients are held in a small ROM. A two-bit rate selector sets how many of the stages take part. Base-rate material passes through all three stages (8x). Double-rate material enters at the second stage (4x). Quad-rate material enters at the last stage only (2x). The stages in front of the entry point stay idle.

Each stage works in polyphase form, so the zero-stuffed samples never enter the multiply-accumulate. For every accepted sample a stage emits two outputs. The first is the in-between value, computed from the symmetric outer taps. The second is the centre tap copied out unchanged. A stage spaces its two outputs by its own gap, and each stage's gap is twice that of the stage after it. As a result the final output strobes come evenly, `OUT_GAP` clocks apart, whenever inputs arrive at the nominal rate. Changing the rate selector flushes every delay line and every pending output.

Top module: `hbi_upsampler`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `out_vld` is 0 and `out_dat` is 0. A reset in the middle of a burst drops every output still pending.
- R2: `rate_sel` encoding: 0 gives 8 output strobes per input strobe, 1 gives 4, and both 2 and 3 give 2.
- R3: Each output strobe lasts one cycle. With inputs every (ratio x `OUT_GAP`) cycles, consecutive output strobes are exactly `OUT_GAP` cycles apart, across burst boundaries as well.
- R4: The half-band taps are (-1, 0, 9, 16, 9, 0, -1)/16. Let a stage's delay line hold d0 (newest) to d3 after a sample is accepted. The stage then emits, in this order, (9*(d1+d2) - (d0+d3))/16 and then d1. In mode 2, an input of 1600 into cleared lines yields -100 then 0, and the next input of 0 yields 900 then 1600.
- R5: Rounding adds half an LSB and then truncates toward minus infinity, so ties go upward. From cleared lines, an input of -8 yields 1, and the following 0 yields -4.
- R6: Results beyond the 24-bit range saturate to 8388607 or -8388608.
- R7: The DC gain is exactly one. After the delay lines fill, a constant input gives outputs equal to that constant in every mode.
- R8: When `rate_sel` differs from the mode in use, the block clears all delay lines and pending outputs. It drops any input strobe in that same cycle and produces no output strobe in the following cycle.
- R9: In modes 2 and 3, `out_vld` goes high exactly two clock edges after the edge that samples `in_vld`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Rate class: 0 = 8x, 1 = 4x, 2 or 3 = 2x |
| in_vld | input | 1 | Input sample strobe |
| in_dat | input | 24 | Signed input sample |
| out_vld | output | 1 | Output sample strobe |
| out_dat | output | 24 | Signed output sample |

## Verification
A table of inputs in the 2x mode walks an impulse through the stage, then exact rounding ties, then full-scale patterns. A design that swapped the phase order, rounded ties the wrong way, or wrapped instead of saturating would return a wrong value on a named row. A mode switch with stale full-scale data in the lines, and a strobe placed on the switch cycle itself, catch a flush that is missing or an input that leaks through. Those faults show up as a nonzero first output. Constant-input bursts at 4x and 8x check the unity gain, the strobe counts and the even spacing. A wrong stage gap or a mis-wired bypass breaks the spacing or the count.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    localparam int SAMPLE_W    = 24;
    localparam int GUARD_W     = 6;
    localparam int ACC_W       = SAMPLE_W + GUARD_W;
    localparam int COEF_W      = 6;
    localparam int COEF_SHIFT  = 4;
    localparam int HB_PAIRS    = 2;
    localparam int NSTAGE      = 3;
    localparam int STAGE_IDX_W = $clog2(NSTAGE);

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [ACC_W-1:0]    acc_t;
    typedef logic signed [COEF_W-1:0]   coef_t;

    typedef enum logic [1:0] {
        RATE_BASE     = 2'd0,
        RATE_DOUBLE   = 2'd1,
        RATE_QUAD     = 2'd2,
        RATE_QUAD_ALT = 2'd3
    } rate_e;

    typedef struct packed {
        logic    vld;
        sample_t dat;
    } strm_t;

    localparam acc_t ROUND_HALF = acc_t'(1 << (COEF_SHIFT - 1));
    localparam acc_t SAT_HI     = acc_t'((2 ** (SAMPLE_W - 1)) - 1);
    localparam acc_t SAT_LO     = acc_t'(-(2 ** (SAMPLE_W - 1)));

    // Half-band coefficient ROM, pair 0 sits next to the centre tap.
    function automatic coef_t hb_coef(input int pair);
        case (pair)
            0:       return coef_t'(9);
            1:       return coef_t'(-1);
            default: return coef_t'(0);
        endcase
    endfunction

    function automatic int active_stages(input rate_e r);
        case (r)
            RATE_BASE:   return 3;
            RATE_DOUBLE: return 2;
            default:     return 1;
        endcase
    endfunction

    function automatic sample_t round_sat(input acc_t acc);
        acc_t r;
        acc_t q;
        r = acc + ROUND_HALF;
        q = r >>> COEF_SHIFT;
        if (q > SAT_HI) begin
            return sample_t'(SAT_HI[SAMPLE_W-1:0]);
        end else if (q < SAT_LO) begin
            return sample_t'(SAT_LO[SAMPLE_W-1:0]);
        end
        return sample_t'(q[SAMPLE_W-1:0]);
    endfunction

endpackage

// File: rtl/hbi_mac.sv
module hbi_mac
    import hbi_pkg::*;
(
    input  sample_t taps [2*HB_PAIRS],
    output sample_t y
);

    acc_t prod [HB_PAIRS];
    acc_t acc;

    for (genvar p = 0; p < HB_PAIRS; p++) begin : g_pair
        acc_t pair_sum;
        assign pair_sum = acc_t'(taps[HB_PAIRS-1-p]) + acc_t'(taps[HB_PAIRS+p]);
        assign prod[p]  = pair_sum * acc_t'(hb_coef(p));
    end

    always_comb begin
        acc = '0;
        for (int p = 0; p < HB_PAIRS; p++) begin
            acc = acc + prod[p];
        end
    end

    assign y = round_sat(acc);

endmodule

// File: rtl/hbi_stage.sv
module hbi_stage
    import hbi_pkg::*;
#(
    parameter int GAP = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  strm_t s_in,
    output strm_t s_out
);

    localparam int NTAP   = 2 * HB_PAIRS;
    localparam int CENTER = HB_PAIRS - 1;
    localparam int CNT_W  = $clog2(GAP + 1);

    sample_t          dly [NTAP];
    sample_t          mid_val;
    logic             emit_a;
    logic             pend_b;
    logic [CNT_W-1:0] cnt;

    hbi_mac u_mac (
        .taps (dly),
        .y    (mid_val)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int k = 0; k < NTAP; k++) begin
                dly[k] <= '0;
            end
            emit_a <= 1'b0;
            pend_b <= 1'b0;
            cnt    <= '0;
            s_out  <= '0;
        end else begin
            s_out.vld <= 1'b0;
            emit_a    <= s_in.vld;
            if (s_in.vld) begin
                dly[0] <= s_in.dat;
                for (int k = 1; k < NTAP; k++) begin
                    dly[k] <= dly[k-1];
                end
            end
            if (emit_a) begin
                s_out.vld <= 1'b1;
                s_out.dat <= mid_val;
                pend_b    <= 1'b1;
                cnt       <= CNT_W'(GAP - 1);
            end else if (pend_b) begin
                if (cnt == '0) begin
                    s_out.vld <= 1'b1;
                    s_out.dat <= dly[CENTER];
                    pend_b    <= 1'b0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/hbi_rate_ctrl.sv
module hbi_rate_ctrl
    import hbi_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             rate_sel,
    output logic                   chg,
    output logic [STAGE_IDX_W-1:0] entry
);

    rate_e mode_q;

    assign chg   = (rate_e'(rate_sel) != mode_q);
    assign entry = STAGE_IDX_W'(NSTAGE - active_stages(mode_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= RATE_BASE;
        end else if (chg) begin
            mode_q <= rate_e'(rate_sel);
        end
    end

endmodule

// File: rtl/hbi_upsampler.sv
module hbi_upsampler
    import hbi_pkg::*;
#(
    parameter int OUT_GAP = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [1:0]                 rate_sel,
    input  logic                       in_vld,
    input  logic signed [SAMPLE_W-1:0] in_dat,
    output logic                       out_vld,
    output logic signed [SAMPLE_W-1:0] out_dat
);

    logic                   rate_chg;
    logic [STAGE_IDX_W-1:0] entry_idx;
    logic [NSTAGE-1:0]      stage_vld;
    strm_t                  ext;
    strm_t                  st_in  [NSTAGE];
    strm_t                  st_out [NSTAGE];

    hbi_rate_ctrl u_rate (
        .clk      (clk),
        .rst      (rst),
        .rate_sel (rate_sel),
        .chg      (rate_chg),
        .entry    (entry_idx)
    );

    assign ext.vld = in_vld && !rate_chg;
    assign ext.dat = in_dat;

    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        localparam int GAP_K = OUT_GAP << (NSTAGE - 1 - k);
        if (k == 0) begin : g_head
            assign st_in[k] = (entry_idx == STAGE_IDX_W'(0)) ? ext : strm_t'('0);
        end else begin : g_tail
            assign st_in[k] = (entry_idx == STAGE_IDX_W'(k)) ? ext :
                              (entry_idx <  STAGE_IDX_W'(k)) ? st_out[k-1] : strm_t'('0);
        end
        hbi_stage #(.GAP(GAP_K)) u_stage (
            .clk   (clk),
            .rst   (rst),
            .clr   (rate_chg),
            .s_in  (st_in[k]),
            .s_out (st_out[k])
        );
        assign stage_vld[k] = st_out[k].vld;
    end

    assign out_vld = st_out[NSTAGE-1].vld;
    assign out_dat = st_out[NSTAGE-1].dat;

endmodule

// File: rtl/hbi_checker.sv
module hbi_checker
    import hbi_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   in_vld,
    input logic                   out_vld,
    input logic                   chg,
    input logic [STAGE_IDX_W-1:0] entry,
    input logic [NSTAGE-1:0]      st_vld
);

    p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        out_vld |=> !out_vld);

    p_flush_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        chg |=> (st_vld == '0));

    p_head_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (entry != '0) |-> !st_vld[0]);

    p_mid_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (entry == STAGE_IDX_W'(NSTAGE - 1)) |-> !st_vld[NSTAGE-2]);

    p_short_latency_r9: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !chg && entry == STAGE_IDX_W'(NSTAGE - 1)) ##1 !chg |=> out_vld);

endmodule

bind hbi_upsampler hbi_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .out_vld (out_vld),
    .chg     (rate_chg),
    .entry   (entry_idx),
    .st_vld  (stage_vld)
);

// File: tb/sim_hbi_upsampler.sv
module sim_hbi_upsampler;

    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 4;
    localparam int LIMIT      = 150000;
    localparam int CAP_N      = 1024;
    localparam int MAXV       = 8388607;
    localparam int MINV       = -8388608;
    localparam int NROW       = 19;

    // 2x mode rows: input, first (mid-phase) output, second (centre) output
    localparam int TV_IN  [NROW] = '{1600, 0, 0, 0, 0,
                                     -8, 0, 0, 0, 0,
                                     MINV, MAXV, MAXV, MINV, 0, MAXV, MINV, MINV, MAXV};
    localparam int TV_MID [NROW] = '{-100, 900, 900, -100, 0,
                                     1, -4, -4, 1, 0,       // R5 ties round upward
                                     524288, -5242880, -524288, MAXV, -524288,
                                     -5767168, 5767167, 524287, MINV}; // R6 at rows 13 and 18
    localparam int TV_CEN [NROW] = '{0, 1600, 0, 0, 0,
                                     0, -8, 0, 0, 0,
                                     0, MINV, MAXV, MAXV, MINV, 0, MAXV, MINV, MINV};

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [1:0]         rate_sel = 2'd0;
    logic               in_vld = 1'b0;
    logic signed [23:0] in_dat = '0;
    logic               out_vld;
    logic signed [23:0] out_dat;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int cap_n    = 0;
    int          cap_t [CAP_N];
    logic signed [23:0] cap [CAP_N];

    hbi_upsampler #(.OUT_GAP(GAP)) u0 (
        .clk      (clk),
        .rst      (rst),
        .rate_sel (rate_sel),
        .in_vld   (in_vld),
        .in_dat   (in_dat),
        .out_vld  (out_vld),
        .out_dat  (out_dat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (out_vld && cap_n < CAP_N) begin
            cap[cap_n]   = out_dat;
            cap_t[cap_n] = cyc;
            cap_n        = cap_n + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input int v, input int period);
        in_vld = 1'b1;
        in_dat = 24'(v);
        @(negedge clk);
        in_vld = 1'b0;
        repeat (period - 1) @(negedge clk);
    endtask

    task automatic check_gaps(input string req, input int base, input int n);
        int bad = 0;
        for (int i = base + 1; i < base + n; i++) begin
            if (cap_t[i] - cap_t[i-1] != GAP) bad++;
        end
        chk(req, bad, 0);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int base;
        // R1: reset state
        repeat (5) @(negedge clk);
        chk("R1 out_vld in reset", int'(out_vld), 0);
        chk("R1 out_dat in reset", int'(out_dat), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 out_vld after reset", int'(out_vld), 0);

        rate_sel = 2'd2;
        repeat (3) @(negedge clk);

        // R4 R5 R6 R9: table walk in 2x mode, one input per 2*GAP cycles
        for (int i = 0; i < NROW; i++) begin
            base   = cap_n;
            in_vld = 1'b1;
            in_dat = 24'(TV_IN[i]);
            @(negedge clk);
            in_vld = 1'b0;
            chk("R9 no strobe one edge after input", int'(out_vld), 0);
            @(negedge clk);
            chk("R9 strobe two edges after input", int'(out_vld), 1);
            repeat (2 * GAP - 2) @(negedge clk);
            chk("R2 two outputs per input in mode 2", cap_n - base, 2);
            chk($sformatf("R4 R5 R6 row %0d mid", i), int'(cap[base]), TV_MID[i]);
            chk($sformatf("R4 R5 R6 row %0d centre", i), int'(cap[base+1]), TV_CEN[i]);
        end
        check_gaps("R3 table spacing", cap_n - 2 * NROW, 2 * NROW);

        // R8: switch away and back with full-scale data in the lines
        base     = cap_n;
        rate_sel = 2'd1;
        repeat (3) @(negedge clk);
        rate_sel = 2'd2;
        repeat (3) @(negedge clk);
        chk("R8 no output across mode switch", cap_n - base, 0);
        send(0, 2 * GAP);
        chk("R8 count after flush", cap_n - base, 2);
        chk("R8 mid after flush", int'(cap[base]), 0);
        chk("R8 centre after flush", int'(cap[base+1]), 0);

        // R8: strobe on the switch cycle is dropped, and the lines are flushed
        send(1600, 2 * GAP);
        base     = cap_n;
        rate_sel = 2'd3;
        send(1600, 10);
        chk("R8 input on switch cycle dropped", cap_n - base, 0);
        send(0, 2 * GAP);
        chk("R8 mid after switch with strobe", int'(cap[base]), 0);
        chk("R8 centre after switch with strobe", int'(cap[base+1]), 0);
        // R2: mode 3 also runs at 2x
        send(0, 2 * GAP);
        send(0, 2 * GAP);
        chk("R2 mode 3 gives 2 per input", cap_n - base, 6);
        check_gaps("R3 mode 3 spacing", base, 6);

        // R7 R2 R3: constant input at 4x
        rate_sel = 2'd1;
        repeat (3) @(negedge clk);
        base = cap_n;
        for (int i = 0; i < 12; i++) send(12345, 4 * GAP);
        repeat (40) @(negedge clk);
        chk("R2 mode 1 gives 4 per input", cap_n - base, 48);
        for (int i = base + 36; i < base + 48; i++) chk("R7 unity DC at 4x", int'(cap[i]), 12345);
        check_gaps("R3 4x spacing", base, 48);

        // R7 R2 R3: constant negative input at 8x
        rate_sel = 2'd0;
        repeat (3) @(negedge clk);
        base = cap_n;
        for (int i = 0; i < 12; i++) send(-77777, 8 * GAP);
        repeat (80) @(negedge clk);
        chk("R2 mode 0 gives 8 per input", cap_n - base, 96);
        for (int i = base + 80; i < base + 96; i++) chk("R7 unity DC at 8x", int'(cap[i]), -77777);
        check_gaps("R3 8x spacing", base, 96);

        // R1: reset during a burst drops what is pending
        send(5000, 4);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst  = 1'b0;
        base = cap_n;
        repeat (60) @(negedge clk);
        chk("R1 pending outputs dropped by reset", cap_n - base, 0);
        chk("R1 out_dat cleared by reset", int'(out_dat), 0);

        finish_run();
    end

endmodule